// File: doc/BRIEF.md
# Privilege-Filtered Event Counter with Overflow Request

This block is a single programmable performance-counting slot. An upstream event selector delivers one pulse per cycle in which the watched event happens. The slot counts that pulse only when nothing blocks it. Three things can block it: a global inhibit bit, a slot-valid qualifier, and a set of per-privilege inhibit flags. Each flag is matched against the current privilege level and against whether the hart runs virtualized.

The count register is split into two half-width words, so a 32-bit register path can reach it as two separate words. A 64-bit path writes it as a whole. When the counter passes its all-ones value it wraps to zero. At that point a sticky overflow flag is set and a local overflow interrupt request is raised, but only if the flag was clear before the wrap. The request stays up until software writes the flag back to zero. Software writes the counter halves and the control flags through a shared data bus. In the narrow register mode, the control flags sit in the upper control word.

Top module: `hpm_event_counter`

## Requirements
- R1: While `count_inhibit` is 1 or `slot_valid` is 0, event pulses leave `cnt_q` unchanged.
- R2: At privilege 3 (machine), events are not counted while the machine-inhibit flag (`ctl_q` bit 62) is 1.
- R3: At privilege 1 (supervisor), events are not counted when one of these holds:
  - `virt_on` is 0 and the supervisor-inhibit flag (bit 61) is 1.
  - `virt_on` is 1 and the virtual-supervisor-inhibit flag (bit 59) is 1.
- R4: At privilege 0 (user), events are not counted when one of these holds:
  - `virt_on` is 0 and the user-inhibit flag (bit 60) is 1.
  - `virt_on` is 1 and the virtual-user-inhibit flag (bit 58) is 1.
  - Privilege value 2 never counts.
- R5: Each admitted event raises `cnt_q` by one, one cycle after the pulse. When the low half is all ones, the event clears the low half and increments the high half.
- R6: An admitted event at the all-ones value makes `cnt_q` zero. If the overflow flag (`ctl_q` bit 63) was 0, the same edge sets it and sets `ovf_irq`.
- R7: A wrap while the overflow flag is 1 raises no new request. Software setting the flag does not raise `ovf_irq`. `ovf_irq` stays 1 until a control write puts 0 in the flag.
- R8: A counter write in a cycle takes priority over that cycle's event.
  - `cnt_wr_lo` loads the low half and `cnt_wr_hi` loads the high half.
  - With `narrow_mode` 0, the halves come from `wr_data[31:0]` and `wr_data[63:32]`.
  - With `narrow_mode` 1, both halves come from `wr_data[31:0]`.
- R9: `ctl_wr` loads the six flags, in this order from high to low: overflow, machine, supervisor, user, virtual-supervisor, virtual-user inhibit.
  - The flags come from `wr_data[63:58]` when `narrow_mode` is 0, and from `wr_data[31:26]` when it is 1.
  - `ctl_q` shows the flags at bits 63:58 and zeros elsewhere.
  - A control write overrides a same-cycle wrap.
- R10: A synchronous reset clears the counter, all flags and `ovf_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 1 | One pulse per occurrence of the selected event |
| count_inhibit | input | 1 | This slot's bit of the global count-inhibit register |
| slot_valid | input | 1 | Slot is implemented and available |
| priv_lvl | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine, 2 reserved |
| virt_on | input | 1 | Hart runs in virtualized mode |
| narrow_mode | input | 1 | 32-bit register access layout |
| cnt_wr_lo | input | 1 | Write low counter half |
| cnt_wr_hi | input | 1 | Write high counter half |
| ctl_wr | input | 1 | Write the control flags |
| wr_data | input | 64 | Software write data |
| cnt_q | output | 64 | Counter value |
| ctl_q | output | 64 | Control word: flags at 63:58 |
| ovf_irq | output | 1 | Local counter-overflow interrupt request |

## Verification
The assertions take for granted that `priv_lvl`, `virt_on` and the qualifiers are stable, known values at each rising edge. They also assume software writes arrive only as single-cycle strobes on the same edge as the data. The bench drives every input just after a falling edge and holds it for a whole cycle, so each edge sees one settled set of values. It reaches the wrap corner by loading values next to all ones through the write strobes rather than by counting up. Its random phase keeps write strobes rare, so that long runs of admitted events still occur.

// File: rtl/hpmc_pkg.sv
package hpmc_pkg;
  localparam int FLAG_W = 6;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } priv_e;

  // packed MSB first: ovf lands on the top control bit
  typedef struct packed {
    logic ovf;
    logic m_inh;
    logic s_inh;
    logic u_inh;
    logic vs_inh;
    logic vu_inh;
  } flags_t;
endpackage

// File: rtl/hpmc_filter.sv
module hpmc_filter
  import hpmc_pkg::*;
(
  input  logic       evt,
  input  logic       glob_inh,
  input  logic       slot_ok,
  input  logic [1:0] priv,
  input  logic       virt,
  input  flags_t     flags,
  output logic       admit
);
  logic blocked;

  always_comb begin
    unique case (priv_e'(priv))
      PRV_MACH:  blocked = flags.m_inh;
      PRV_SUPER: blocked = virt ? flags.vs_inh : flags.s_inh;
      PRV_USER:  blocked = virt ? flags.vu_inh : flags.u_inh;
      default:   blocked = 1'b1;
    endcase
  end

  assign admit = evt & ~glob_inh & slot_ok & ~blocked;
endmodule

// File: rtl/hpmc_count.sv
module hpmc_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             admit,
  input  logic             narrow,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam int HALF_W = CNT_W / 2;
  localparam int NHALF  = 2;

  logic [HALF_W-1:0] half_q [NHALF];
  logic [NHALF-1:0]  half_full;
  logic [NHALF-1:0]  half_wen;
  logic              bump;

  assign bump = admit & ~wr_lo & ~wr_hi;
  assign half_wen = {wr_hi, wr_lo};

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] wdat;
    logic              step;
    assign wdat = narrow ? wr_data[HALF_W-1:0] : wr_data[h*HALF_W +: HALF_W];
    if (h == 0) begin : g_lo
      assign step = bump;
    end else begin : g_hi
      assign step = bump & half_full[0];
    end
    assign half_full[h] = &half_q[h];

    always_ff @(posedge clk) begin
      if (rst)              half_q[h] <= '0;
      else if (half_wen[h]) half_q[h] <= wdat;
      else if (step)        half_q[h] <= half_q[h] + 1'b1;
    end
  end

  assign cnt_q = {half_q[1], half_q[0]};
  assign wrap  = bump & (&half_full);
endmodule

// File: rtl/hpmc_flags.sv
module hpmc_flags
  import hpmc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             narrow,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wrap,
  output flags_t           flags_q,
  output logic             irq_q
);
  localparam int HALF_W = CNT_W / 2;

  flags_t wflags;
  assign wflags = narrow ? flags_t'(wr_data[HALF_W-1 -: FLAG_W])
                         : flags_t'(wr_data[CNT_W-1 -: FLAG_W]);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else if (ctl_wr) begin
      flags_q <= wflags;
      irq_q   <= irq_q & wflags.ovf;
    end else if (wrap && !flags_q.ovf) begin
      flags_q.ovf <= 1'b1;
      irq_q       <= 1'b1;
    end
  end
endmodule

// File: rtl/hpm_event_counter.sv
module hpm_event_counter
  import hpmc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_pulse,
  input  logic             count_inhibit,
  input  logic             slot_valid,
  input  logic [1:0]       priv_lvl,
  input  logic             virt_on,
  input  logic             narrow_mode,
  input  logic             cnt_wr_lo,
  input  logic             cnt_wr_hi,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ctl_q,
  output logic             ovf_irq
);
  flags_t flags;
  logic   admit;
  logic   wrap;

  hpmc_filter u_filter (
    .evt      (evt_pulse),
    .glob_inh (count_inhibit),
    .slot_ok  (slot_valid),
    .priv     (priv_lvl),
    .virt     (virt_on),
    .flags    (flags),
    .admit    (admit)
  );

  hpmc_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .admit   (admit),
    .narrow  (narrow_mode),
    .wr_lo   (cnt_wr_lo),
    .wr_hi   (cnt_wr_hi),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .wrap    (wrap)
  );

  hpmc_flags #(.CNT_W(CNT_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .narrow  (narrow_mode),
    .ctl_wr  (ctl_wr),
    .wr_data (wr_data),
    .wrap    (wrap),
    .flags_q (flags),
    .irq_q   (ovf_irq)
  );

  assign ctl_q = {flags, {(CNT_W-FLAG_W){1'b0}}};
endmodule

// File: rtl/hpm_event_counter_chk.sv
module hpm_event_counter_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_pulse,
  input logic             count_inhibit,
  input logic             slot_valid,
  input logic [1:0]       priv_lvl,
  input logic             virt_on,
  input logic             narrow_mode,
  input logic             cnt_wr_lo,
  input logic             cnt_wr_hi,
  input logic             ctl_wr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ctl_q,
  input logic             ovf_irq
);
  logic no_cwr;
  assign no_cwr = !cnt_wr_lo && !cnt_wr_hi;

  a_r1_inhibit_hold: assert property (@(posedge clk) disable iff (rst)
    ((count_inhibit || !slot_valid) && no_cwr) |=> $stable(cnt_q));

  a_r2_minh_hold: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl == 2'd3 && ctl_q[CNT_W-2] && no_cwr) |=> $stable(cnt_q));

  a_r4_rsvd_priv_hold: assert property (@(posedge clk) disable iff (rst)
    (priv_lvl == 2'd2 && no_cwr) |=> $stable(cnt_q));

  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse && !count_inhibit && slot_valid && priv_lvl == 2'd3 &&
     !ctl_q[CNT_W-2] && no_cwr && (&cnt_q)) |=> (cnt_q == '0));

  a_r7_irq_needs_of: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> ctl_q[CNT_W-1]);

  a_r7_no_rearm: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[CNT_W-1] && !ctl_wr) |=> !$rose(ovf_irq));

  a_r8_wide_write: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr_lo && cnt_wr_hi && !narrow_mode) |=> (cnt_q == $past(wr_data)));
endmodule

bind hpm_event_counter hpm_event_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_hpm_event_counter.sv
module test_hpm_event_counter;
  logic        clk = 1'b0;
  logic        rst, evt, ginh, valid, virt, narrow, wlo, whi, ctlw;
  logic [1:0]  priv;
  logic [63:0] wd;
  logic [63:0] cnt_q, ctl_q;
  logic        ovf_irq;

  logic [63:0] m_cnt;
  logic [5:0]  m_fl;   // 5 ovf,4 m,3 s,2 u,1 vs,0 vu
  logic        m_irq;
  int          n_run = 0, n_fail = 0;
  string       cur_req = "R10";

  always #4 clk = ~clk;

  hpm_event_counter i_hpm_event_counter (
    .clk(clk), .rst(rst), .evt_pulse(evt), .count_inhibit(ginh),
    .slot_valid(valid), .priv_lvl(priv), .virt_on(virt),
    .narrow_mode(narrow), .cnt_wr_lo(wlo), .cnt_wr_hi(whi), .ctl_wr(ctlw),
    .wr_data(wd), .cnt_q(cnt_q), .ctl_q(ctl_q), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // advance one clock with the inputs currently driven, then compare
  task automatic step();
    logic blk, adm, wrapped;
    logic [5:0] nf;
    wrapped = 1'b0;
    if (rst) begin
      m_cnt = '0; m_fl = '0; m_irq = 1'b0;
    end else begin
      case (priv)
        2'd3: blk = m_fl[4];
        2'd1: blk = virt ? m_fl[1] : m_fl[3];
        2'd0: blk = virt ? m_fl[0] : m_fl[2];
        default: blk = 1'b1;
      endcase
      adm = evt && !ginh && valid && !blk;
      if (wlo || whi) begin
        if (wlo) m_cnt[31:0]  = wd[31:0];
        if (whi) m_cnt[63:32] = narrow ? wd[31:0] : wd[63:32];
      end else if (adm) begin
        wrapped = (m_cnt == 64'hFFFF_FFFF_FFFF_FFFF);
        m_cnt = m_cnt + 64'd1;
      end
      if (ctlw) begin
        nf = narrow ? wd[31:26] : wd[63:58];
        m_fl = nf;
        m_irq = m_irq && nf[5];
      end else if (wrapped && !m_fl[5]) begin
        m_fl[5] = 1'b1;
        m_irq = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("cnt_q", cnt_q, m_cnt);
    chk("ctl_q", ctl_q, {m_fl, 58'd0});
    chk("ovf_irq", {63'd0, ovf_irq}, {63'd0, m_irq});
  endtask

  task automatic idle();
    evt = 0; wlo = 0; whi = 0; ctlw = 0; wd = '0;
  endtask

  task automatic set_flags(input logic [5:0] f, input logic nar, input logic [63:0] junk);
    narrow = nar;
    wd = nar ? {junk[63:32], f, junk[25:0]} : {f, junk[57:0]};
    ctlw = 1; step(); idle();
  endtask

  task automatic load64(input logic [63:0] v);
    narrow = 0; wd = v; wlo = 1; whi = 1; step(); idle();
  endtask

  task automatic events(input int n, input logic [1:0] p, input logic v);
    priv = p; virt = v; evt = 1;
    for (int i = 0; i < n; i++) step();
    evt = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(); rst = 1; ginh = 0; valid = 1; priv = 2'd3; virt = 0; narrow = 0;
    @(negedge clk);
    cur_req = "R10"; step(); step();
    rst = 0;
    events(3, 2'd3, 0);
    rst = 1; step(); rst = 0;   // R10 reset after counting

    cur_req = "R1";
    ginh = 1; events(4, 2'd3, 0); ginh = 0;
    valid = 0; events(4, 2'd3, 0); valid = 1;
    events(2, 2'd3, 0);

    cur_req = "R2";
    set_flags(6'b010000, 0, 64'h0123_4567_89AB_CDEF);
    events(4, 2'd3, 0);
    events(2, 2'd1, 0);

    cur_req = "R3";
    set_flags(6'b001000, 0, '0);
    events(3, 2'd1, 0); events(3, 2'd1, 1);
    set_flags(6'b000010, 0, '0);
    events(3, 2'd1, 1); events(3, 2'd1, 0);

    cur_req = "R4";
    set_flags(6'b000100, 0, '0);
    events(3, 2'd0, 0); events(3, 2'd0, 1);
    set_flags(6'b000001, 0, '0);
    events(3, 2'd0, 1); events(3, 2'd0, 0);
    set_flags(6'b000000, 0, '0);
    events(4, 2'd2, 0); events(4, 2'd2, 1);

    cur_req = "R5";
    load64(64'h0000_0000_FFFF_FFFE);
    events(3, 2'd3, 0);
    narrow = 1; events(2, 2'd3, 0); narrow = 0;

    cur_req = "R6";
    load64(64'hFFFF_FFFF_FFFF_FFFD);
    events(4, 2'd3, 0);

    cur_req = "R7";
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    events(2, 2'd3, 0);
    set_flags(6'b100000, 0, '0);
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    events(2, 2'd3, 0);
    set_flags(6'b000000, 1, 64'hFFFF_FFFF_03FF_FFFF);
    set_flags(6'b100000, 1, '0);
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    events(2, 2'd3, 0);
    set_flags(6'b000000, 0, '0);
    narrow = 1; wd = 64'hAAAA_AAAA_FFFF_FFFF; wlo = 1; whi = 1; step(); idle();
    events(2, 2'd3, 0); narrow = 0;

    cur_req = "R8";
    priv = 2'd3; evt = 1;
    narrow = 0; wd = 64'h1111_2222_3333_4444; wlo = 1; whi = 1; step();
    wlo = 0; whi = 0; wd = 64'h5555_6666_7777_8888; wlo = 1; step(); wlo = 0;
    narrow = 1; wd = 64'h9999_AAAA_BBBB_CCCC; whi = 1; step(); whi = 0;
    wd = 64'hDEAD_BEEF_0000_0007; wlo = 1; step(); idle(); narrow = 0;
    step();

    cur_req = "R9";
    set_flags(6'b011010, 1, 64'h5A5A_5A5A_FC00_0000);
    set_flags(6'b000101, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    set_flags(6'b000000, 0, '0);
    load64(64'hFFFF_FFFF_FFFF_FFFF);
    priv = 2'd3; evt = 1; wd = {6'b000000, 58'd0}; ctlw = 1; step(); idle();
    step();

    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      evt = r[0] | r[1];
      ginh = (r[4:2] == 3'd0);
      valid = (r[7:5] != 3'd0);
      priv = r[9:8];
      virt = r[10];
      narrow = r[11];
      wlo = (r[17:12] == 6'd0);
      whi = (r[17:12] == 6'd1) || (r[17:12] == 6'd0 && r[18]);
      ctlw = (r[25:19] < 7'd3);
      wd = {$urandom, $urandom};
      if (ctlw) begin
        wd[63:58] = {r[26], 1'b0, r[27], r[28], 2'b00};
        wd[31:26] = {r[26], 1'b0, r[27], r[28], 2'b00};
      end
      if (wlo || whi) begin
        if (r[29]) wd = 64'hFFFF_FFFF_FFFF_FFF0 | {60'd0, r[31:28]};
        if (r[29] && narrow) wd[31:0] = 32'hFFFF_FFF0 | {28'd0, r[31:28]};
      end
      step();
    end
    idle(); ginh = 0; valid = 1;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule